// File: doc/BRIEF.md
# Two-Probe Direct-Mapped Read Cache

This block is a small read cache that is direct-mapped but lets each address live in one of two slots. The first slot is the ordinary index taken from the address. The second slot is that index with its most significant bit inverted. A lookup reads the home slot in the cycle the request is accepted. If that misses, the cache reads the second slot in the next cycle. Every line stores a relocation flag that says whether it sits in its second slot. The tag compare includes this flag, so the full address of any resident line can be rebuilt.

A hit in the second slot costs one extra cycle. It is followed by one exchange cycle that moves the hot line back to its home slot and sends the former occupant of the home slot to the other slot. When both probes miss, the cache fetches one word from memory and places it in the home slot. The old home line, if valid, is pushed into the other slot.

The processor side uses a valid/ready request with a registered response of variable latency. The memory side is a request held until the fill word arrives. Each line holds a single data word, so the line address is the full request address. Writes are not handled.

Top module: `hr_cache`

## Requirements
- R1: A request whose line is valid in its home slot with the relocation flag clear gives `rsp_valid_o` with that line's data in the cycle right after acceptance. `req_ready_o` stays high, so hits can be issued back to back.
- R2: After a home-slot miss, the second probe uses the index with bit IDX_W-1 inverted. A hit there gives the response two cycles after acceptance.
- R3: `req_ready_o` is low from the cycle after a missed home probe until the operation ends. After a second-slot hit it is low for exactly two cycles (second probe and exchange).
- R4: After a second-slot hit, the hit line is in its home slot with the flag clear. The former home line is in the other slot with its flag inverted, so a repeat of the same address hits in one cycle.
- R5: When both probes miss, `mem_req_o` rises with `mem_addr_o` equal to the full request address. The response carries `mem_data_i` from the cycle `mem_valid_i` was high, and that word is then resident in the home slot with the flag clear.
- R6: On a double miss, a valid former home line moves to the other slot with its flag inverted. A line that was itself relocated therefore returns to its own home slot.
- R7: A home probe matches only lines whose flag is clear, and a second probe matches only lines whose flag is set. A relocated line never answers for the address that shares its tag and slot.
- R8: After reset all lines are invalid, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_o` are 0.
- R9: While `mem_valid_i` is low, `mem_req_o` stays high and `mem_addr_o` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Cache can accept a request |
| req_addr_i | input | ADDR_W | Request word address |
| rsp_valid_o | output | 1 | Response data valid (one cycle) |
| rsp_data_o | output | DATA_W | Response data |
| mem_req_o | output | 1 | Fill request to memory |
| mem_addr_o | output | ADDR_W | Fill address |
| mem_valid_i | input | 1 | Fill data present |
| mem_data_i | input | DATA_W | Fill data |

## Verification
The bench makes a pair of addresses that share a home slot fight over it. It then checks the three outcomes: a relocated line answers in two cycles, comes back in one cycle once exchanged, and the displaced partner is found in the other slot. A design that skipped the exchange, or failed to invert the flag of a moved line, would show the wrong latency or stale data on the next access. An aliasing address is also tested: it has the same tag as a relocated line and indexes that line's current slot. A design that ignored the flag in the compare would return the relocated line's data for it instead of going to memory. A double miss whose home slot holds a relocated line checks that the line is sent back to its own home and not into exile.

// File: rtl/hr_cache_pkg.sv
package hr_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PROBE2 = 2'd1,
    ST_SWAP   = 2'd2,
    ST_FILL   = 2'd3
  } hr_state_e;

endpackage

// File: rtl/hr_probe.sv
module hr_probe #(
  parameter int unsigned TAG_W = 4
) (
  input  logic             vld_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             rh_i,
  input  logic [TAG_W-1:0] cmp_tag_i,
  input  logic             want_rh_i,
  output logic             hit_o
);
  // flag is part of the compare (R7)
  assign hit_o = vld_i && (rh_i == want_rh_i) && (tag_i == cmp_tag_i);
endmodule

// File: rtl/hr_line_store.sv
module hr_line_store #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic              rd_a_vld_o,
  output logic [TAG_W-1:0]  rd_a_tag_o,
  output logic              rd_a_rh_o,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic              rd_b_vld_o,
  output logic [TAG_W-1:0]  rd_b_tag_o,
  output logic              rd_b_rh_o,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wa_en_i,
  input  logic [IDX_W-1:0]  wa_idx_i,
  input  logic              wa_vld_i,
  input  logic [TAG_W-1:0]  wa_tag_i,
  input  logic              wa_rh_i,
  input  logic [DATA_W-1:0] wa_data_i,
  input  logic              wb_en_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic              wb_vld_i,
  input  logic [TAG_W-1:0]  wb_tag_i,
  input  logic              wb_rh_i,
  input  logic [DATA_W-1:0] wb_data_i
);
  localparam int unsigned LINES = 1 << IDX_W;

  logic              vld_q  [LINES];
  logic              rh_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        rh_q[g]   <= 1'b0;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (wa_en_i && wa_idx_i == IDX_W'(g)) begin
        vld_q[g]  <= wa_vld_i;
        rh_q[g]   <= wa_rh_i;
        tag_q[g]  <= wa_tag_i;
        data_q[g] <= wa_data_i;
      end else if (wb_en_i && wb_idx_i == IDX_W'(g)) begin
        vld_q[g]  <= wb_vld_i;
        rh_q[g]   <= wb_rh_i;
        tag_q[g]  <= wb_tag_i;
        data_q[g] <= wb_data_i;
      end
    end
  end

  assign rd_a_vld_o  = vld_q[rd_a_idx_i];
  assign rd_a_tag_o  = tag_q[rd_a_idx_i];
  assign rd_a_rh_o   = rh_q[rd_a_idx_i];
  assign rd_a_data_o = data_q[rd_a_idx_i];
  assign rd_b_vld_o  = vld_q[rd_b_idx_i];
  assign rd_b_tag_o  = tag_q[rd_b_idx_i];
  assign rd_b_rh_o   = rh_q[rd_b_idx_i];
  assign rd_b_data_o = data_q[rd_b_idx_i];

  // both write ports target the two partner slots, never the same one
  p_wr_distinct_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wa_en_i && wb_en_i) |-> (wa_idx_i != wb_idx_i));
endmodule

// File: rtl/hr_cache.sv
module hr_cache
  import hr_cache_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i
);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;
  localparam logic [IDX_W-1:0] FLIP = {1'b1, {(IDX_W-1){1'b0}}};

  hr_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic [IDX_W-1:0]  pri_idx, alt_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic              accept, p_hit, r_hit;

  logic              a_vld, a_rh, b_vld, b_rh;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;

  logic              wa_en, wa_vld, wa_rh, wb_en, wb_vld, wb_rh;
  logic [IDX_W-1:0]  wa_idx, wb_idx;
  logic [TAG_W-1:0]  wa_tag, wb_tag;
  logic [DATA_W-1:0] wa_data, wb_data;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign pri_idx     = (state_q == ST_IDLE) ? req_addr_i[IDX_W-1:0] : addr_q[IDX_W-1:0];
  assign cur_tag     = (state_q == ST_IDLE) ? req_addr_i[ADDR_W-1:IDX_W] : addr_q[ADDR_W-1:IDX_W];
  assign alt_idx     = addr_q[IDX_W-1:0] ^ FLIP;

  hr_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .rd_a_idx_i(pri_idx), .rd_a_vld_o(a_vld), .rd_a_tag_o(a_tag),
    .rd_a_rh_o(a_rh), .rd_a_data_o(a_data),
    .rd_b_idx_i(alt_idx), .rd_b_vld_o(b_vld), .rd_b_tag_o(b_tag),
    .rd_b_rh_o(b_rh), .rd_b_data_o(b_data),
    .wa_en_i(wa_en), .wa_idx_i(wa_idx), .wa_vld_i(wa_vld), .wa_tag_i(wa_tag),
    .wa_rh_i(wa_rh), .wa_data_i(wa_data),
    .wb_en_i(wb_en), .wb_idx_i(wb_idx), .wb_vld_i(wb_vld), .wb_tag_i(wb_tag),
    .wb_rh_i(wb_rh), .wb_data_i(wb_data)
  );

  hr_probe #(.TAG_W(TAG_W)) u_probe_pri (
    .vld_i(a_vld), .tag_i(a_tag), .rh_i(a_rh),
    .cmp_tag_i(cur_tag), .want_rh_i(1'b0), .hit_o(p_hit)
  );

  hr_probe #(.TAG_W(TAG_W)) u_probe_alt (
    .vld_i(b_vld), .tag_i(b_tag), .rh_i(b_rh),
    .cmp_tag_i(addr_q[ADDR_W-1:IDX_W]), .want_rh_i(1'b1), .hit_o(r_hit)
  );

  always_comb begin
    state_d = state_q;
    wa_en = 1'b0; wa_idx = pri_idx; wa_vld = 1'b0; wa_tag = '0; wa_rh = 1'b0; wa_data = '0;
    wb_en = 1'b0; wb_idx = alt_idx; wb_vld = 1'b0; wb_tag = '0; wb_rh = 1'b0; wb_data = '0;
    unique case (state_q)
      ST_IDLE:   if (accept && !p_hit) state_d = ST_PROBE2;
      ST_PROBE2: state_d = r_hit ? ST_SWAP : ST_FILL;
      ST_SWAP: begin
        // hot line goes home; home occupant moves across with flag inverted
        wa_en = 1'b1; wa_vld = b_vld; wa_tag = b_tag; wa_rh = 1'b0; wa_data = b_data;
        wb_en = 1'b1; wb_vld = a_vld; wb_tag = a_tag; wb_rh = !a_rh; wb_data = a_data;
        state_d = ST_IDLE;
      end
      ST_FILL: if (mem_valid_i) begin
        wa_en = 1'b1; wa_vld = 1'b1; wa_tag = addr_q[ADDR_W-1:IDX_W]; wa_rh = 1'b0;
        wa_data = mem_data_i;
        wb_en = a_vld; wb_vld = a_vld; wb_tag = a_tag; wb_rh = !a_rh; wb_data = a_data;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= 1'b0;
      if (accept) addr_q <= req_addr_i;
      if (state_q == ST_IDLE && accept && p_hit) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= a_data;
      end else if (state_q == ST_PROBE2 && r_hit) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= b_data;
      end else if (state_q == ST_FILL && mem_valid_i) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= mem_data_i;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign mem_req_o   = (state_q == ST_FILL);
  assign mem_addr_o  = addr_q;

  p_hit_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && p_hit) |=> (rsp_valid_o && req_ready_o));

  p_rehash_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROBE2 && r_hit) |=> (rsp_valid_o && !req_ready_o) ##1 req_ready_o);

  p_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !p_hit) |=> !req_ready_o ##1 !req_ready_o);

  p_fill_rsp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i) |=> (rsp_valid_o && rsp_data_o == $past(mem_data_i)));

  p_mem_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));
endmodule

// File: tb/hr_cache_tb.sv
module hr_cache_tb;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 4;
  localparam int DATA_W = 8;
  localparam int LINES  = 1 << IDX_W;
  localparam int MEM_LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, rsp_valid, mem_req;
  logic [DATA_W-1:0] rsp_data;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_valid = 1'b0;
  logic [DATA_W-1:0] mem_data = '0;

  always #10 clk = ~clk;

  hr_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_valid_i(mem_valid), .mem_data_i(mem_data)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return a ^ 8'h5A;
  endfunction

  // scoreboard queues
  logic [DATA_W-1:0] q_data[$];
  int                q_cyc[$];
  string             q_req[$];

  // reference model of slot contents
  bit         m_v [LINES];
  bit         m_r [LINES];
  logic [3:0] m_t [LINES];
  logic [ADDR_W-1:0] exp_mem_addr = '0;

  function automatic int predict(input logic [ADDR_W-1:0] a);
    int i, j, k;
    bit tv, tr;
    logic [3:0] tt, t;
    i = int'(a[IDX_W-1:0]);
    j = i ^ (LINES / 2);
    t = a[ADDR_W-1:IDX_W];
    if (m_v[i] && !m_r[i] && m_t[i] == t) k = 0;
    else if (m_v[j] && m_r[j] && m_t[j] == t) begin
      k = 1;
      tv = m_v[i]; tr = m_r[i]; tt = m_t[i];
      m_v[i] = 1'b1; m_r[i] = 1'b0; m_t[i] = t;
      m_v[j] = tv; m_r[j] = !tr; m_t[j] = tt;
    end else begin
      k = 2;
      if (m_v[i]) begin
        m_v[j] = 1'b1; m_r[j] = !m_r[i]; m_t[j] = m_t[i];
      end
      m_v[i] = 1'b1; m_r[i] = 1'b0; m_t[i] = t;
    end
    return k;
  endfunction

  // driver: called at a negedge with req_ready high
  task automatic send(input logic [ADDR_W-1:0] a, input string req);
    int kind, k, stall;
    kind = predict(a);
    k = cyc + 1;
    q_data.push_back(mem_word(a));
    q_cyc.push_back(kind == 0 ? k : (kind == 1 ? k + 1 : -1));
    q_req.push_back(req);
    if (kind == 2) exp_mem_addr = a;
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    stall = 0;
    while (!req_ready) begin
      stall++;
      @(negedge clk);
    end
    if (kind == 0) chk(stall == 0, "R1", "ready stall after home hit", stall, 0);
    else if (kind == 1) chk(stall == 2, "R3", "ready stall after second-slot hit", stall, 2);
    else chk(stall >= 2, "R3", "ready stall after double miss", stall, 2);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R1", "unexpected response", int'(rsp_data), 0);
      end else begin
        logic [DATA_W-1:0] ed;
        int ec;
        string er;
        ed = q_data.pop_front();
        ec = q_cyc.pop_front();
        er = q_req.pop_front();
        chk(rsp_data == ed, er, "response data", int'(rsp_data), int'(ed));
        if (ec >= 0)
          chk(cyc == ec, (ec == cyc || q_req.size() >= 0) ? er : er, "response cycle", cyc, ec);
      end
    end
  end

  // memory model
  int mcnt = 0;
  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid <= 1'b0;
    end else if (rst_n && mem_req) begin
      mcnt = mcnt + 1;
      if (mcnt == MEM_LAT) begin
        mcnt = 0;
        chk(mem_addr == exp_mem_addr, "R5", "fill address", int'(mem_addr), int'(exp_mem_addr));
        mem_valid <= 1'b1;
        mem_data  <= mem_word(mem_addr);
      end
    end
  end

  initial begin
    #(20 * 20000);
    chk(1'b0, "R1", "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_v[i] = 1'b0; m_r[i] = 1'b0; m_t[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R8", "ready in reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R8", "rsp_valid in reset", int'(rsp_valid), 0);
    chk(mem_req == 1'b0, "R8", "mem_req in reset", int'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    send(8'h35, "R8");   // cold cache: must go to memory
    send(8'h75, "R6");   // evicts 0x35 into slot 13, flag set
    send(8'h35, "R2");   // second-slot hit, then exchange
    send(8'h35, "R4");   // now home again: one-cycle hit
    send(8'h75, "R4");   // displaced partner found in other slot
    send(8'h3D, "R7");   // same tag as relocated 0x35 in slot 13: must miss
    send(8'h35, "R6");   // relocated line sent back home by the fill
    send(8'h75, "R5");   // evicted, refetched

    for (int a = 0; a < 8; a++) send(ADDR_W'(a), "R5");
    for (int a = 0; a < 8; a++) send(ADDR_W'(a), "R1");
    for (int a = 0; a < 8; a++) send(ADDR_W'(8'h80 + a), "R6");
    for (int a = 0; a < 8; a++) send(ADDR_W'(a), "R2");
    for (int a = 7; a >= 0; a--) send(ADDR_W'(a), "R1");

    repeat (5) @(negedge clk);
    chk(q_data.size() == 0, "R1", "responses outstanding", q_data.size(), 0);
    chk(req_ready == 1'b1 && mem_req == 1'b0, "R9", "idle at end",
        int'({req_ready, mem_req}), 2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule